// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives characters from one asynchronous serial line that rests high between characters. A divider inside it produces a sampling tick at sixteen times the bit rate. The line first passes through a two-flop synchronizer. On each tick the receiver looks for a high-to-low change, which marks a possible start bit. Half a bit later it samples the line again, and it drops the attempt if the line has gone back high. Once the start is confirmed, the receiver samples every following bit once per bit period, close to the middle of the bit.

The character format is set by static inputs:
- 5 to 8 data bits.
- Even, odd or no parity.
- One or two stop bits.

The receiver captures the format at the start edge, so a new format may be applied between characters. Each received character is delivered as a zero-extended parallel word, together with a parity-error flag and a framing-error flag. A one-clock strobe marks the update. A new start edge is accepted right after the last stop-bit sample, so characters can follow one another with no idle time.

Top module: `async_rx`

## Requirements
- R1: After reset, `data_o`, `valid_o`, `par_err_o` and `frm_err_o` are all 0.
- R2: A line that stays high produces no character. A low pulse that has ended before the half-bit recheck (8 ticks after the edge) is discarded as a false start and produces no character. The next valid frame is then received normally.
- R3: Data bits are taken least significant bit first. `len_i` 00/01/10/11 selects 5/6/7/8 data bits. Bits of `data_o` above the selected length are 0.
- R4: `par_i` 00 means no parity bit, 01 means even parity and 10 means odd parity; 11 behaves as 00. `par_err_o` is 1 when the data bits plus the parity bit do not have the selected parity. It is 0 when parity is off.
- R5: `stop_i` 0 selects one stop bit and 1 selects two. `frm_err_o` is 1 when any stop bit reads low at its centre sample.
- R6: Each received frame raises `valid_o` for exactly one clock. `data_o` and both error flags change only in that clock and hold until the next character.
- R7: Frames sent back to back, each start bit directly after the previous stop bit, are all received.
- R8: The sampling tick occurs once every `CLK_DIV` clocks, so one bit period is 16×`CLK_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| len_i | input | 2 | Data length: 00=5, 01=6, 10=7, 11=8 bits |
| par_i | input | 2 | Parity: 00 none, 01 even, 10 odd, 11 none |
| stop_i | input | 1 | Stop bits: 0 one, 1 two |
| data_o | output | 8 | Received character, zero-extended |
| valid_o | output | 1 | One-clock strobe for a new character |
| par_err_o | output | 1 | Parity mismatch on the last character |
| frm_err_o | output | 1 | Low stop bit on the last character |

## Verification
The hardest case to reach from the ports is a failure in the second stop bit while the first is good. Close behind it is a false start that sits entirely inside the half-bit recheck window. Both depend on where the bench places a line edge relative to the receiver's internal tick count. The bench builds every frame in units of the configured bit period. It produces the second-stop case by driving the first stop bit high and the second low. It produces a false start by holding the line low for well under half a bit, then confirms that no strobe follows and that the next frame is received intact. Every combination of the 24 formats is swept with edge-value data patterns, sent back to back, plus corrupted parity bits in every parity mode.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int unsigned OSR   = 16;
  localparam int unsigned HALF  = OSR / 2;
  localparam int unsigned MIN_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/async_rx_tick.sv
module async_rx_tick #(
  parameter int unsigned CLK_DIV = 54
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          tick_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          if (cnt_q == CW'(CLK_DIV - 1)) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
          end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
          end
        end
      end
      assign tick_o = tick_q;

      // R8: ticks never land on adjacent clocks when dividing
      p_tick_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        par_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = $clog2(DATA_W);

  rx_state_e         state_q;
  logic              prev_q;
  logic [CW-1:0]     tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic              sbit_q;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        par_q;
  logic              stop2_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pacc_q;
  logic              perr_q;
  logic              ferr_q;

  logic [BW-1:0]     last_bit;
  logic              par_on;
  logic              bit_end;

  assign last_bit = BW'(len_q) + BW'(MIN_W - 1);
  assign par_on   = (par_q == PAR_EVEN) || (par_q == PAR_ODD);
  assign bit_end  = (tcnt_q == CW'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      prev_q    <= 1'b1;
      tcnt_q    <= '0;
      bcnt_q    <= '0;
      sbit_q    <= 1'b0;
      len_q     <= '0;
      par_q     <= PAR_NONE;
      stop2_q   <= 1'b0;
      shreg_q   <= '0;
      pacc_q    <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rx_i;
        unique case (state_q)
          ST_IDLE: begin
            if (prev_q && !rx_i) begin
              state_q <= ST_START;
              tcnt_q  <= '0;
              bcnt_q  <= '0;
              sbit_q  <= 1'b0;
              len_q   <= len_i;
              par_q   <= par_i;
              stop2_q <= stop_i;
              shreg_q <= '0;
              pacc_q  <= 1'b0;
              perr_q  <= 1'b0;
              ferr_q  <= 1'b0;
            end
          end
          ST_START: begin
            if (tcnt_q == CW'(HALF - 1)) begin
              tcnt_q  <= '0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;  // high again: false start
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              tcnt_q          <= '0;
              shreg_q[bcnt_q] <= rx_i;
              pacc_q          <= pacc_q ^ rx_i;
              if (bcnt_q == last_bit) state_q <= par_on ? ST_PAR : ST_STOP;
              else                    bcnt_q  <= bcnt_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              tcnt_q  <= '0;
              perr_q  <= pacc_q ^ rx_i ^ (par_q == PAR_ODD);
              state_q <= ST_STOP;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              tcnt_q <= '0;
              if (sbit_q == stop2_q) begin
                state_q   <= ST_IDLE;
                data_o    <= shreg_q;
                par_err_o <= perr_q;
                frm_err_o <= ferr_q | ~rx_i;
                valid_o   <= 1'b1;
              end else begin
                sbit_q <= 1'b1;
                ferr_q <= ferr_q | ~rx_i;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: strobe is a single clock wide
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6: outputs move only with the strobe
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(par_err_o) && $stable(frm_err_o)));

  // R6: strobe comes only out of the stop phase
  p_valid_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(state_q) == ST_STOP));

  // R2: high line at the half-bit recheck abandons the frame
  p_false_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && tcnt_q == CW'(HALF - 1) && rx_i)
      |=> (state_q == ST_IDLE));

  // R3: bit index stays within the selected length
  p_bit_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (bcnt_q <= last_bit));

  // R5: a low stop sample is always recorded
  p_stop_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && tick_i && bit_end && !rx_i) |=> (ferr_q || frm_err_o));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int unsigned CLK_DIV = 54,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LEN_W   = 2,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        par_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  logic tick;
  logic rx_s;

  async_rx_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  async_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  async_rx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rx_i      (rx_s),
    .len_i     (len_i),
    .par_i     (par_i),
    .stop_i    (stop_i),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o)
  );
endmodule

// File: tb/sim_async_rx.sv
`timescale 1ns/1ps
module sim_async_rx;
  localparam int DIV  = 2;
  localparam int BITC = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] len = 2'b11;
  logic [1:0] par = 2'b00;
  logic       stop = 1'b0;
  logic [7:0] data;
  logic       valid, pe, fe;

  int n_chk = 0;
  int n_bad = 0;
  int vcnt = 0;
  int exp_cnt = 0;
  bit done = 0;
  bit dbl = 0;
  bit pv = 0;
  logic [7:0] cap_d;
  logic       cap_pe, cap_fe;

  always #4 clk = ~clk;

  async_rx #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .len_i(len), .par_i(par),
    .stop_i(stop), .data_o(data), .valid_o(valid), .par_err_o(pe), .frm_err_o(fe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        vcnt++;
        cap_d = data; cap_pe = pe; cap_fe = fe;
        if (pv) dbl = 1;
      end
      pv = valid;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par,
                      input logic bad_stop);
    int nb;
    logic pb;
    nb = int'(len) + 5;
    pb = ^(d & 8'((1 << nb) - 1));
    if (par == 2'b10) pb = ~pb;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par == 2'b01 || par == 2'b10) drive_bit(pb ^ bad_par);
    if (stop) begin
      drive_bit(1'b1);
      drive_bit(~bad_stop);
    end else begin
      drive_bit(~bad_stop);
    end
    exp_cnt++;
  endtask

  task automatic check_last(input logic [7:0] d, input logic epe, input logic efe,
                            input string ctx);
    logic [7:0] dm;
    dm = d & 8'((1 << (int'(len) + 5)) - 1);
    chk(vcnt == exp_cnt, {ctx, " R7 count"}, vcnt, exp_cnt);
    chk(cap_d == dm, {ctx, " R3 data"}, cap_d, dm);
    chk(cap_pe == epe, {ctx, " R4 parity flag"}, cap_pe, epe);
    chk(cap_fe == efe, {ctx, " R5 framing flag"}, cap_fe, efe);
  endtask

  function automatic logic [7:0] pat(input int k);
    case (k)
      0: pat = 8'h00;
      1: pat = 8'hFF;
      2: pat = 8'h55;
      3: pat = 8'hAA;
      default: pat = 8'((k * 37 + 11) & 255);
    endcase
  endfunction

  initial begin
    int tcnt;
    repeat (5) @(negedge clk);
    chk(data == 8'h00 && !valid && !pe && !fe, "R1 reset outputs",
        {data, valid, pe, fe}, 0);
    rst_n = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    chk(vcnt == 0, "R2 idle line", vcnt, 0);

    // R8: tick spacing seen through bit timing: count clocks between tick pulses
    tcnt = 0;
    @(negedge clk);
    while (!u0.tick) @(negedge clk);
    @(negedge clk);
    tcnt = 1;
    while (!u0.tick) begin @(negedge clk); tcnt++; end
    chk(tcnt == DIV, "R8 tick period", tcnt, DIV);

    // R3/R4/R5/R7: sweep every format, frames back to back
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 3; p++) begin
        for (int l = 0; l < 4; l++) begin
          len = 2'(l); par = 2'(p); stop = 1'(s);
          for (int k = 0; k < 6; k++) begin
            send(pat(k + l), 1'b0, 1'b0);
            check_last(pat(k + l), 1'b0, 1'b0, "sweep");
          end
        end
      end
    end

    // R4: corrupted parity in even and odd modes
    for (int p = 1; p < 3; p++) begin
      for (int l = 0; l < 4; l++) begin
        len = 2'(l); par = 2'(p); stop = 1'b0;
        send(pat(l + 7), 1'b1, 1'b0);
        check_last(pat(l + 7), 1'b1, 1'b0, "badpar");
        send(pat(l + 9), 1'b0, 1'b0);
        check_last(pat(l + 9), 1'b0, 1'b0, "recover");
      end
    end

    // R4: code 11 acts as no parity
    len = 2'b11; par = 2'b11; stop = 1'b0;
    send(8'hC3, 1'b0, 1'b0);
    check_last(8'hC3, 1'b0, 1'b0, "par11");

    // R5: single stop low
    par = 2'b01; stop = 1'b0;
    send(8'h5A, 1'b0, 1'b1);
    drive_bit(1'b1);
    check_last(8'h5A, 1'b0, 1'b1, "stop1 low");
    // R5: first stop good, second stop low
    stop = 1'b1;
    send(8'hA5, 1'b0, 1'b1);
    drive_bit(1'b1);
    check_last(8'hA5, 1'b0, 1'b1, "stop2 low");

    // R2: false starts of 1 and 6 ticks
    rx = 1'b0; repeat (DIV) @(negedge clk);
    rx = 1'b1; repeat (2 * BITC) @(negedge clk);
    rx = 1'b0; repeat (6 * DIV) @(negedge clk);
    rx = 1'b1; repeat (2 * BITC) @(negedge clk);
    chk(vcnt == exp_cnt, "R2 false start ignored", vcnt, exp_cnt);
    par = 2'b00; stop = 1'b0; len = 2'b11;
    send(8'h96, 1'b0, 1'b0);
    check_last(8'h96, 1'b0, 1'b0, "R2 after false start");

    repeat (BITC) @(negedge clk);
    chk(!dbl, "R6 single-clock strobe", dbl, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule